// File: doc/BRIEF.md
# LIN Status Flag Controller

This block keeps the status flags of a LIN master or slave controller and raises interrupt requests from them. The protocol engine sends it single-cycle event pulses:

- header done
- first response byte received
- frame or wake-up transmitted
- frame or wake-up received
- six separate error detections

It also takes three control inputs. Two request the target mode: reset mode, and operation versus wake-up mode. The third is a pulse that marks the start of a new communication. Software clears flags through a small write port. Writing 0 to a flag bit clears it. Writing 1 has no effect.

The requested mode does not take effect at once. The block models the time the module needs to actually settle in a new mode. A new mode is applied after the request has differed from the current mode for `SETTLE_CYC` clock cycles. The status bits report only the applied mode, and entering reset mode wipes every flag. Each of the four interrupting flags (transmit-end, receive-end, error, header-done) produces a one-cycle request when it rises.

Top module: `lin_status_ctrl`

## Requirements
- R1: After reset `st_active` reads 0, because the block starts in reset mode. While `req_rst_mode` differs from the applied mode, a counter runs. On the `SETTLE_CYC`-th consecutive cycle of difference the new mode is applied, and `st_active` then becomes the inverse of the request. It reads 1 after the module has left reset mode and 0 after it has entered it. If the request matches the applied mode, the counter restarts.
- R2: `st_wake` reports the applied sub-mode: 0 for operation, 1 for wake-up. It is updated by the same settle rule as R1, applied to the pair (`req_rst_mode`, `req_wake`).
- R3: `flg_tx` sets one cycle after an `ev_tx_done` pulse, provided the module is out of reset mode.
- R4: `flg_rx` sets one cycle after an `ev_rx_done` pulse, provided the module is out of reset mode.
- R5: `flg_hdr` sets one cycle after an `ev_hdr_done` pulse, provided the module is out of reset mode.
- R6: The error sources map to `ev_err` and `err_bits` bit positions as follows: 0 parity/identifier, 1 checksum, 2 framing, 3 frame timeout, 4 physical bus, 5 bit error. A pulse on any of these bits sets the matching `err_bits` bit and the summary flag `flg_err`.
- R7: The status register has `sw_sel`=0. Its bit positions are: tx 0, rx 1, error 3, header 5, first byte 6.
  - A write of 0 to one of these bits clears that flag.
  - A `com_start` pulse clears every flag.
  - A write of 1 has no effect.
  - If a set event and a clear arrive in the same cycle, the set event wins.
- R8: The error register has `sw_sel`=1, with bits 5:0 as in R6. Writing 0 to any of these bits clears that error bit and also clears `flg_err`.
- R9: `flg_b1` sets on `ev_byte1_rx` only when all of the following hold:
  - `rsp_dir_rx`=1
  - `rsp_len` is non-zero (0 means checksum only)
  - the module is in operation mode, not wake-up mode

  It has no interrupt.
- R10: In the cycle the module enters reset mode, all flags and error bits clear, even if a set event arrives in that cycle. While in reset mode, events are ignored.
- R11: Each of `irq_tx`, `irq_rx`, `irq_err` and `irq_hdr` is high for exactly one cycle: the first cycle in which its flag reads 1. The mode status bits never raise an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rst_mode | input | 1 | Requested mode: 1 reset mode, 0 active |
| req_wake | input | 1 | Requested sub-mode: 1 wake-up, 0 operation |
| com_start | input | 1 | Start-of-communication pulse |
| ev_hdr_done | input | 1 | Header completed pulse |
| ev_byte1_rx | input | 1 | First response byte received pulse |
| ev_tx_done | input | 1 | Frame or wake-up transmitted pulse |
| ev_rx_done | input | 1 | Frame or wake-up received pulse |
| ev_err | input | 6 | Error detection pulses (R6 positions) |
| rsp_dir_rx | input | 1 | Response direction: 1 receive |
| rsp_len | input | 4 | Configured response data bytes |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 1 | 0 status register, 1 error register |
| sw_wdata | input | 8 | Software write data |
| st_active | output | 1 | 1 once out of reset mode |
| st_wake | output | 1 | Applied sub-mode, 1 wake-up |
| flg_tx | output | 1 | Transmit-end flag |
| flg_rx | output | 1 | Receive-end flag |
| flg_err | output | 1 | Summary error flag |
| flg_hdr | output | 1 | Header-done flag |
| flg_b1 | output | 1 | First-data-byte flag |
| err_bits | output | 6 | Individual error flags |
| irq_tx | output | 1 | Transmit-end interrupt pulse |
| irq_rx | output | 1 | Receive-end interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |
| irq_hdr | output | 1 | Header-done interrupt pulse |

## Verification
The hardest case to reach from the ports is the exact cycle in which reset mode is applied while a set event arrives, since that needs a request held steady for the full settle window and a pulse timed to its last cycle. A directed sequence counts the settle cycles and fires every event in that cycle. The same-cycle set-versus-clear races and zero-length responses in wake-up versus operation mode are covered by random pulses mixed with random register writes over long runs in each mode.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;
    localparam int N_ERR = 6;
    localparam int LEN_W = 4;
    localparam int ST_TX  = 0;
    localparam int ST_RX  = 1;
    localparam int ST_ERR = 3;
    localparam int ST_HDR = 5;
    localparam int ST_B1  = 6;

    typedef struct packed {
        logic             tx;
        logic             rx;
        logic             err;
        logic             hdr;
        logic             b1;
        logic [N_ERR-1:0] eb;
    } flags_t;

    typedef struct packed {
        logic tx;
        logic rx;
        logic err;
        logic hdr;
    } irqs_t;
endpackage

// File: rtl/lin_mode_seq.sv
module lin_mode_seq #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_rst,
    input  logic req_wake,
    output logic in_rst,
    output logic in_wake,
    output logic enter_rst
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        logic             rst;
        logic             wake;
        logic [CNT_W-1:0] cnt;
    } mode_t;

    mode_t m_d, m_q;
    logic  differ, apply;

    always_comb begin
        m_d       = m_q;
        differ    = (req_rst != m_q.rst) || (req_wake != m_q.wake);
        apply     = differ && (m_q.cnt == LAST);
        enter_rst = apply && req_rst && !m_q.rst;
        if (!differ) begin
            m_d.cnt = '0;
        end else if (apply) begin
            m_d.rst  = req_rst;
            m_d.wake = req_wake;
            m_d.cnt  = '0;
        end else begin
            m_d.cnt = m_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{rst: 1'b1, wake: 1'b0, cnt: '0};
        end else begin
            m_q <= m_d;
        end
    end

    assign in_rst  = m_q.rst;
    assign in_wake = m_q.wake;
endmodule

// File: rtl/lin_flag_core.sv
module lin_flag_core
    import lin_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_rst,
    input  logic             in_wake,
    input  logic             enter_rst,
    input  logic             com_start,
    input  logic             ev_hdr_done,
    input  logic             ev_byte1_rx,
    input  logic             ev_tx_done,
    input  logic             ev_rx_done,
    input  logic [N_ERR-1:0] ev_err,
    input  logic             rsp_dir_rx,
    input  logic [LEN_W-1:0] rsp_len,
    input  logic             sw_wr,
    input  logic             sw_sel,
    input  logic [7:0]       sw_wdata,
    output flags_t           flags,
    output irqs_t            irqs
);
    flags_t           f_d, f_q;
    irqs_t            i_d, i_q;
    logic [7:0]       st_zero;
    logic [N_ERR-1:0] eb_zero;
    logic             b1_set;

    always_comb begin
        f_d     = f_q;
        st_zero = (sw_wr && !sw_sel) ? ~sw_wdata : 8'h00;
        eb_zero = (sw_wr && sw_sel) ? ~sw_wdata[N_ERR-1:0] : '0;
        b1_set  = ev_byte1_rx && rsp_dir_rx && (rsp_len != '0) && !in_wake;

        if (ev_tx_done)                         f_d.tx = 1'b1;
        else if (com_start || st_zero[ST_TX])   f_d.tx = 1'b0;

        if (ev_rx_done)                         f_d.rx = 1'b1;
        else if (com_start || st_zero[ST_RX])   f_d.rx = 1'b0;

        if (ev_hdr_done)                        f_d.hdr = 1'b1;
        else if (com_start || st_zero[ST_HDR])  f_d.hdr = 1'b0;

        if (b1_set)                             f_d.b1 = 1'b1;
        else if (com_start || st_zero[ST_B1])   f_d.b1 = 1'b0;

        for (int i = 0; i < N_ERR; i++) begin
            if (ev_err[i])                      f_d.eb[i] = 1'b1;
            else if (com_start || eb_zero[i])   f_d.eb[i] = 1'b0;
        end

        if (|ev_err)                            f_d.err = 1'b1;
        else if (com_start || st_zero[ST_ERR] || (|eb_zero))
                                                f_d.err = 1'b0;

        if (in_rst || enter_rst) f_d = '0;

        i_d.tx  = f_d.tx  && !f_q.tx;
        i_d.rx  = f_d.rx  && !f_q.rx;
        i_d.err = f_d.err && !f_q.err;
        i_d.hdr = f_d.hdr && !f_q.hdr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
            i_q <= '0;
        end else begin
            f_q <= f_d;
            i_q <= i_d;
        end
    end

    assign flags = f_q;
    assign irqs  = i_q;
endmodule

// File: rtl/lin_status_ctrl.sv
module lin_status_ctrl
    import lin_stat_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_rst_mode,
    input  logic             req_wake,
    input  logic             com_start,
    input  logic             ev_hdr_done,
    input  logic             ev_byte1_rx,
    input  logic             ev_tx_done,
    input  logic             ev_rx_done,
    input  logic [5:0]       ev_err,
    input  logic             rsp_dir_rx,
    input  logic [3:0]       rsp_len,
    input  logic             sw_wr,
    input  logic             sw_sel,
    input  logic [7:0]       sw_wdata,
    output logic             st_active,
    output logic             st_wake,
    output logic             flg_tx,
    output logic             flg_rx,
    output logic             flg_err,
    output logic             flg_hdr,
    output logic             flg_b1,
    output logic [5:0]       err_bits,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             irq_err,
    output logic             irq_hdr
);
    logic   in_rst, in_wake, enter_rst;
    flags_t flags;
    irqs_t  irqs;

    lin_mode_seq #(.SETTLE_CYC(SETTLE_CYC)) mode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_rst   (req_rst_mode),
        .req_wake  (req_wake),
        .in_rst    (in_rst),
        .in_wake   (in_wake),
        .enter_rst (enter_rst)
    );

    lin_flag_core flag_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_rst      (in_rst),
        .in_wake     (in_wake),
        .enter_rst   (enter_rst),
        .com_start   (com_start),
        .ev_hdr_done (ev_hdr_done),
        .ev_byte1_rx (ev_byte1_rx),
        .ev_tx_done  (ev_tx_done),
        .ev_rx_done  (ev_rx_done),
        .ev_err      (ev_err),
        .rsp_dir_rx  (rsp_dir_rx),
        .rsp_len     (rsp_len),
        .sw_wr       (sw_wr),
        .sw_sel      (sw_sel),
        .sw_wdata    (sw_wdata),
        .flags       (flags),
        .irqs        (irqs)
    );

    assign st_active = !in_rst;
    assign st_wake   = in_wake;
    assign flg_tx    = flags.tx;
    assign flg_rx    = flags.rx;
    assign flg_err   = flags.err;
    assign flg_hdr   = flags.hdr;
    assign flg_b1    = flags.b1;
    assign err_bits  = flags.eb;
    assign irq_tx    = irqs.tx;
    assign irq_rx    = irqs.rx;
    assign irq_err   = irqs.err;
    assign irq_hdr   = irqs.hdr;
endmodule

// File: rtl/lin_status_ctrl_chk.sv
module lin_status_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_rst_mode,
    input logic       req_wake,
    input logic       com_start,
    input logic       ev_hdr_done,
    input logic       ev_byte1_rx,
    input logic       ev_tx_done,
    input logic       ev_rx_done,
    input logic [5:0] ev_err,
    input logic       rsp_dir_rx,
    input logic [3:0] rsp_len,
    input logic       sw_wr,
    input logic       sw_sel,
    input logic [7:0] sw_wdata,
    input logic       st_active,
    input logic       st_wake,
    input logic       flg_tx,
    input logic       flg_rx,
    input logic       flg_err,
    input logic       flg_hdr,
    input logic       flg_b1,
    input logic [5:0] err_bits,
    input logic       irq_tx,
    input logic       irq_rx,
    input logic       irq_err,
    input logic       irq_hdr
);
    a_r1_mode_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_active) |-> (st_active == !$past(req_rst_mode)));

    a_r10_reset_mode_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !st_active |-> (!flg_tx && !flg_rx && !flg_err && !flg_hdr && !flg_b1 && err_bits == 6'd0));

    a_r3_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_done && st_active && !req_rst_mode) |=> flg_tx);

    a_r6_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev_err) && st_active && !req_rst_mode) |=> flg_err);

    a_r9_b1_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg_b1) |-> ($past(rsp_len) != 4'd0 && $past(rsp_dir_rx) && !$past(st_wake)));

    a_r11_irq_tx_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> (flg_tx && !$past(flg_tx)));

    a_r11_irq_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |=> !irq_err);

    a_r11_irq_rx_hdr_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx |-> flg_rx) and (irq_hdr |-> flg_hdr));
endmodule

bind lin_status_ctrl lin_status_ctrl_chk chk_i (.*);

// File: tb/lin_status_ctrl_tb_top.sv
module lin_status_ctrl_tb_top;
    localparam int SETTLE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_rst_mode = 1'b1, req_wake = 1'b0, com_start = 1'b0;
    logic ev_hdr_done = 1'b0, ev_byte1_rx = 1'b0, ev_tx_done = 1'b0, ev_rx_done = 1'b0;
    logic [5:0] ev_err = '0;
    logic rsp_dir_rx = 1'b0;
    logic [3:0] rsp_len = '0;
    logic sw_wr = 1'b0, sw_sel = 1'b0;
    logic [7:0] sw_wdata = '0;
    logic st_active, st_wake, flg_tx, flg_rx, flg_err, flg_hdr, flg_b1;
    logic [5:0] err_bits;
    logic irq_tx, irq_rx, irq_err, irq_hdr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model
    bit m_rst, m_wake;
    int m_cnt;
    bit m_tx, m_rx, m_err, m_hdr, m_b1;
    bit [5:0] m_eb;
    bit x_tx, x_rx, x_err, x_hdr;

    always #5 clk = ~clk;

    lin_status_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (.*);

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit nxt(bit old, bit set, bit clr);
        return set ? 1'b1 : (clr ? 1'b0 : old);
    endfunction

    task automatic model_step();
        bit enter = 0;
        bit o_tx = m_tx, o_rx = m_rx, o_err = m_err, o_hdr = m_hdr;
        bit [7:0] sz = (sw_wr && !sw_sel) ? ~sw_wdata : 8'h00;
        bit [5:0] ez = (sw_wr && sw_sel) ? ~sw_wdata[5:0] : 6'h00;
        bit was_rst = m_rst, was_wake = m_wake;
        if (req_rst_mode != m_rst || req_wake != m_wake) begin
            if (m_cnt == SETTLE - 1) begin
                enter = req_rst_mode && !m_rst;
                m_rst = req_rst_mode; m_wake = req_wake; m_cnt = 0;
            end else m_cnt++;
        end else m_cnt = 0;
        if (was_rst || enter) begin
            m_tx = 0; m_rx = 0; m_err = 0; m_hdr = 0; m_b1 = 0; m_eb = 0;
        end else begin
            m_tx  = nxt(m_tx, ev_tx_done, com_start || sz[0]);
            m_rx  = nxt(m_rx, ev_rx_done, com_start || sz[1]);
            m_err = nxt(m_err, |ev_err, com_start || sz[3] || (|ez));
            m_hdr = nxt(m_hdr, ev_hdr_done, com_start || sz[5]);
            m_b1  = nxt(m_b1, ev_byte1_rx && rsp_dir_rx && rsp_len != 0 && !was_wake,
                        com_start || sz[6]);
            for (int i = 0; i < 6; i++)
                m_eb[i] = nxt(m_eb[i], ev_err[i], com_start || ez[i]);
        end
        x_tx = m_tx && !o_tx; x_rx = m_rx && !o_rx;
        x_err = m_err && !o_err; x_hdr = m_hdr && !o_hdr;
    endtask

    task automatic check_all();
        chk("R1", st_active, !m_rst);
        chk("R2", st_wake, m_wake);
        chk("R3", flg_tx, m_tx);
        chk("R4", flg_rx, m_rx);
        chk("R5", flg_hdr, m_hdr);
        chk("R6", err_bits, m_eb);
        chk("R8", flg_err, m_err);
        chk("R9", flg_b1, m_b1);
        chk("R11", {irq_tx, irq_rx, irq_err, irq_hdr}, {x_tx, x_rx, x_err, x_hdr});
    endtask

    task automatic clear_pulses();
        com_start = 0; ev_hdr_done = 0; ev_byte1_rx = 0; ev_tx_done = 0;
        ev_rx_done = 0; ev_err = 0; sw_wr = 0;
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        check_all();
        clear_pulses();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        m_rst = 1; m_wake = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        // reset state, R1 and R10
        chk("R1", st_active, 0);
        chk("R10", {flg_tx, flg_rx, flg_err, flg_hdr, flg_b1, err_bits}, 0);
        rst_n = 1;
        // events in reset mode are ignored (R10)
        ev_tx_done = 1; ev_err = 6'h3F; tick();
        chk("R10", flg_tx, 0);
        // leave reset into operation: stays 0 for SETTLE-1 cycles (R1)
        req_rst_mode = 0;
        tick(); chk("R1", st_active, 0);
        idle(SETTLE - 1); chk("R1", st_active, 1);
        // R7: same-cycle set wins over clear
        ev_tx_done = 1; com_start = 1; tick(); chk("R7", flg_tx, 1);
        // R7: write of ones does nothing
        sw_wr = 1; sw_sel = 0; sw_wdata = 8'hFF; tick(); chk("R7", flg_tx, 1);
        sw_wr = 1; sw_wdata = 8'hFE; tick(); chk("R7", flg_tx, 0);
        // R6 bit positions, R8 clear on one zero
        ev_err = 6'b010000; tick(); chk("R6", err_bits, 6'b010000);
        sw_wr = 1; sw_sel = 1; sw_wdata = 8'hFE; tick();
        chk("R8", flg_err, 0); chk("R8", err_bits, 6'b010000);
        // R9: zero length suppressed, non-zero sets
        rsp_dir_rx = 1; rsp_len = 0; ev_byte1_rx = 1; tick(); chk("R9", flg_b1, 0);
        rsp_len = 3; ev_byte1_rx = 1; tick(); chk("R9", flg_b1, 1);
        rsp_dir_rx = 0; com_start = 1; tick();
        ev_byte1_rx = 1; rsp_len = 2; tick(); chk("R9", flg_b1, 0);
        // R2: switch to wake-up; b1 suppressed there
        req_wake = 1; idle(SETTLE); chk("R2", st_wake, 1);
        rsp_dir_rx = 1; ev_byte1_rx = 1; tick(); chk("R9", flg_b1, 0);
        ev_rx_done = 1; tick(); chk("R4", flg_rx, 1);
        req_wake = 0; idle(SETTLE);
        // R10: reset entry in the same cycle as set events
        ev_hdr_done = 1; tick();
        req_rst_mode = 1; idle(SETTLE - 1);
        ev_tx_done = 1; ev_hdr_done = 1; ev_err = 6'h21; tick();
        chk("R10", {flg_tx, flg_hdr, flg_err}, 0); chk("R1", st_active, 0);
        req_rst_mode = 0; idle(SETTLE);
        // constrained random
        for (int k = 0; k < 4000; k++) begin
            req_rst_mode = ($urandom % 200) == 0 ? ~req_rst_mode : req_rst_mode;
            if (($urandom % 100) == 0) req_wake = ~req_wake;
            com_start   = ($urandom % 16) == 0;
            ev_hdr_done = ($urandom % 6) == 0;
            ev_byte1_rx = ($urandom % 6) == 0;
            ev_tx_done  = ($urandom % 6) == 0;
            ev_rx_done  = ($urandom % 6) == 0;
            ev_err      = (($urandom % 5) == 0) ? 6'(1 << ($urandom % 6)) : 6'h00;
            rsp_dir_rx  = $urandom % 2;
            rsp_len     = (($urandom % 4) == 0) ? 4'd0 : 4'($urandom);
            sw_wr       = ($urandom % 8) == 0;
            sw_sel      = $urandom % 2;
            sw_wdata    = (($urandom % 2) == 0) ? 8'hFF : 8'($urandom);
            tick();
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        process_seed();
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic process_seed();
        void'($urandom(32'h5EED_1234));
    endtask
endmodule